// File: doc/BRIEF.md
# Per-Output PWM Gate Selector

This block decides, for each of sixteen low-side outputs, whether its gate should be driven on. Each output has a serial-interface on/off bit, a PWM enable bit and a combine-select bit. A PWM-enabled output follows its on/off bit combined with one shared PWM pin, by AND or by OR as its select bit says. An output with PWM disabled follows its on/off bit. Eight of the sixteen outputs also have a dedicated direct-PWM pin, which is OR-ed in while PWM is disabled on that output.

The shared pin and the direct pins are asynchronous. Each passes through a two-flop synchroniser. The control bits are captured into a register stage that reset clears. The final request is then masked by the per-output fault-off vector and by the global shutdown line from the fault logic, and it leaves the block registered. The block has a single clock and a synchronous active-low reset.

Top module: `pwm_gate_select`

## Requirements
- R1: For an output that has no direct pin (outputs 2-5 and 10-13) and whose PWM enable bit is 0, the gate equals its on/off bit.
- R2: Direct pin bits 0 to 7 belong to outputs 0, 1, 6, 7, 8, 9, 14 and 15, in that order. While PWM enable is 0 on such an output, its gate is the OR of its on/off bit and its direct pin.
- R3: With PWM enable 1 and combine-select 0, the gate is the AND of the on/off bit and the shared PWM pin.
- R4: With PWM enable 1 and combine-select 1, the gate is the OR of the on/off bit and the shared PWM pin.
- R5: While PWM enable is 1 on an output, its direct pin has no effect on its gate.
- R6: A set fault-off bit forces that output's gate to 0 and leaves every other output unchanged.
- R7: A set global shutdown forces all gates to 0.
- R8: A change on the fault-off bits or on global shutdown reaches the gate after 1 rising edge. A change on the control bits takes 2 edges, and a change on a PWM pin takes 3 edges.
- R9: While reset is low, all gates are 0 and the captured control bits (including the PWM enable mask) are cleared, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_on_i | input | 16 | On/off bit per output |
| pwm_en_i | input | 16 | PWM enable per output |
| pwm_or_i | input | 16 | Combine select per output, 0 = AND, 1 = OR |
| pwm_shared_i | input | 1 | Shared PWM pin, asynchronous |
| pwm_direct_i | input | 8 | Direct PWM pins for outputs 0,1,6,7,8,9,14,15 |
| fault_off_i | input | 16 | Per-output forced-off from fault logic |
| global_off_i | input | 1 | Global shutdown from fault logic |
| gate_o | output | 16 | Registered gate request per output |

## Verification
The hardest case to reach is a cycle in which the three input groups meet at the output register with three different ages. The gate then combines fault inputs from the last edge, control bits from one edge earlier and pin values from two edges earlier. A bench model that ignores this skew hides latency errors. The random stimulus changes every input group on every cycle. The bench keeps a three-deep history of what it drove and builds each expected vector from the matching history slot. Directed steps then hold one group still while another toggles, so each latency is counted edge by edge.

// File: rtl/pwm_gate_pkg.sv
// Package: shared helpers for the PWM gate selector.
// Assumes masks are at most 64 bits wide.
package pwm_gate_pkg;

    // Number of set bits in a mask.
    function automatic int count_ones(input logic [63:0] mask);
        int n;
        n = 0;
        for (int b = 0; b < 64; b++) begin
            if (mask[b]) n++;
        end
        return n;
    endfunction

    // Position among the direct pins of the output at index idx: how many mask bits are set below idx.
    function automatic int slot_of(input logic [63:0] mask, input int idx);
        int n;
        n = 0;
        for (int b = 0; b < 64; b++) begin
            if (b < idx && mask[b]) n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/pwm_gate_sync.sv
// Module: multi-bit synchroniser chain for asynchronous PWM pins.
// Each bit is treated on its own; no coherence across bits is assumed.
// Reset drives every stage to 0, which matches a pulled-low pin.
module pwm_gate_sync #(
    parameter int WIDTH  = 9,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop captures the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_i;
                end
            end else begin : g_next
                // Each later flop takes the stage before it.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pwm_gate_ctrl.sv
// Module: capture stage for the per-output control words.
// The inputs are register values held elsewhere. Reset clears the captured copies,
// so no output can be PWM-enabled or switched on while reset is low.
module pwm_gate_ctrl #(
    parameter int N_OUT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_OUT-1:0] spi_on_i,
    input  logic [N_OUT-1:0] pwm_en_i,
    input  logic [N_OUT-1:0] pwm_or_i,
    output logic [N_OUT-1:0] spi_q,
    output logic [N_OUT-1:0] en_q,
    output logic [N_OUT-1:0] or_q
);
    // Capture all three control words each cycle; reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spi_q <= '0;
            en_q  <= '0;
            or_q  <= '0;
        end else begin
            spi_q <= spi_on_i;
            en_q  <= pwm_en_i;
            or_q  <= pwm_or_i;
        end
    end
endmodule

// File: rtl/pwm_gate_lane.sv
// Module: gate selection and fault masking for one output.
// Assumes pins arrive already synchronised. direct_i is tied low by the parent
// when the output has no direct pin. The gate is registered.
module pwm_gate_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_on_i,
    input  logic pwm_en_i,
    input  logic pwm_or_i,
    input  logic shared_i,
    input  logic direct_i,
    input  logic fault_off_i,
    input  logic global_off_i,
    output logic gate_o
);
    logic shared_mix;
    logic plain_mix;
    logic request;

    // Combine the on/off bit with the shared pin, by OR or by AND.
    always_comb begin
        if (pwm_or_i) shared_mix = spi_on_i | shared_i;
        else          shared_mix = spi_on_i & shared_i;
    end

    // Without PWM enable, the on/off bit joins the direct pin if one exists.
    assign plain_mix = spi_on_i | direct_i;

    // The enable bit picks the source.
    assign request = pwm_en_i ? shared_mix : plain_mix;

    // Register the request with the fault masks applied.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_o <= 1'b0;
        else        gate_o <= request & ~fault_off_i & ~global_off_i;
    end
endmodule

// File: rtl/pwm_gate_select.sv
// Module: top of the per-output PWM gate selector.
// The control words are register values. The PWM pins are asynchronous and pulled low.
// The fault masks are synchronous to clk. Direct pins are assigned in ascending order
// to the outputs whose bit is set in DIRECT_MASK.
module pwm_gate_select #(
    parameter int               N_OUT       = 16,
    parameter logic [N_OUT-1:0] DIRECT_MASK = 16'hC3C3,
    parameter int               N_DIRECT    = pwm_gate_pkg::count_ones(64'(DIRECT_MASK)),
    parameter int               SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_OUT-1:0]    spi_on_i,
    input  logic [N_OUT-1:0]    pwm_en_i,
    input  logic [N_OUT-1:0]    pwm_or_i,
    input  logic                pwm_shared_i,
    input  logic [N_DIRECT-1:0] pwm_direct_i,
    input  logic [N_OUT-1:0]    fault_off_i,
    input  logic                global_off_i,
    output logic [N_OUT-1:0]    gate_o
);
    localparam int PIN_W = N_DIRECT + 1;

    logic [PIN_W-1:0]    pins_s;
    logic                shared_s;
    logic [N_DIRECT-1:0] direct_s;
    logic [N_OUT-1:0]    direct_vec;
    logic [N_OUT-1:0]    ctl_spi;
    logic [N_OUT-1:0]    ctl_en;
    logic [N_OUT-1:0]    ctl_or;

    pwm_gate_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({pwm_shared_i, pwm_direct_i}),
        .sync_o  (pins_s)
    );

    assign shared_s = pins_s[PIN_W-1];
    assign direct_s = pins_s[N_DIRECT-1:0];

    pwm_gate_ctrl #(.N_OUT(N_OUT)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_on_i (spi_on_i),
        .pwm_en_i (pwm_en_i),
        .pwm_or_i (pwm_or_i),
        .spi_q    (ctl_spi),
        .en_q     (ctl_en),
        .or_q     (ctl_or)
    );

    genvar i;
    generate
        for (i = 0; i < N_OUT; i++) begin : g_out
            // Route each direct pin to its output; outputs without one see 0.
            if (DIRECT_MASK[i]) begin : g_dir
                assign direct_vec[i] = direct_s[pwm_gate_pkg::slot_of(64'(DIRECT_MASK), i)];
            end else begin : g_nodir
                assign direct_vec[i] = 1'b0;
            end

            pwm_gate_lane u_lane (
                .clk          (clk),
                .rst_n        (rst_n),
                .spi_on_i     (ctl_spi[i]),
                .pwm_en_i     (ctl_en[i]),
                .pwm_or_i     (ctl_or[i]),
                .shared_i     (shared_s),
                .direct_i     (direct_vec[i]),
                .fault_off_i  (fault_off_i[i]),
                .global_off_i (global_off_i),
                .gate_o       (gate_o[i])
            );
        end
    endgenerate
endmodule

// File: rtl/pwm_gate_select_chk.sv
// Module: property checker for pwm_gate_select, attached by bind.
// Compares the captured control state one edge back with the registered gates.
module pwm_gate_select_chk #(
    parameter int N_OUT = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_OUT-1:0] gate_o,
    input logic [N_OUT-1:0] fault_off_i,
    input logic             global_off_i,
    input logic [N_OUT-1:0] ctl_spi,
    input logic [N_OUT-1:0] ctl_en,
    input logic [N_OUT-1:0] ctl_or
);
    logic rst_low_q;

    // R3: an AND-mode PWM output whose on/off bit was 0 cannot be on.
    p_and_needs_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_o & $past(ctl_en & ~ctl_or & ~ctl_spi)) == '0)
        else $error("R3 AND-mode gate on without on/off bit");

    // R4: an OR-mode PWM output with its on/off bit set is on unless a fault mask is set.
    p_or_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_o | $past(fault_off_i) | {N_OUT{$past(global_off_i)}})
         & $past(ctl_en & ctl_or & ctl_spi)) == $past(ctl_en & ctl_or & ctl_spi))
        else $error("R4 OR-mode gate off with on/off bit set");

    // R6: a fault-off bit forces that gate low on the next edge.
    p_fault_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (gate_o & $past(fault_off_i)) == '0)
        else $error("R6 gate on under fault-off");

    // R7: global shutdown clears every gate on the next edge.
    p_global_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        global_off_i |=> gate_o == '0)
        else $error("R7 gate on under global shutdown");

    // Remembers whether reset was low at the last edge.
    always_ff @(posedge clk) rst_low_q <= !rst_n;

    // R9: after an edge with reset low, all gates are low.
    always @(negedge clk) begin
        if (rst_low_q) begin
            p_reset_r9: assert (gate_o == '0) else $error("R9 gate on in reset");
        end
    end
endmodule

bind pwm_gate_select pwm_gate_select_chk #(.N_OUT(N_OUT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .gate_o       (gate_o),
    .fault_off_i  (fault_off_i),
    .global_off_i (global_off_i),
    .ctl_spi      (ctl_spi),
    .ctl_en       (ctl_en),
    .ctl_or       (ctl_or)
);

// File: tb/pwm_gate_select_bench.sv
// Bench: directed cases plus seeded random stimulus, compared with a latency-aware model.
module pwm_gate_select_bench;
    localparam logic [15:0] DIR_OUTS = 16'hC3C3;  // outputs 0,1,6,7,8,9,14,15 (R2)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] spi_on = '0, pwm_en = '0, pwm_or = '0, fault_off = '0;
    logic        shared_pin = 1'b0, global_off = 1'b0;
    logic [7:0]  direct_pin = '0;
    logic [15:0] gate;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Drive history: index 0 is the most recent negedge.
    logic [15:0] spi_h [3], en_h [3], or_h [3], flt_h [3];
    logic        shr_h [3], glb_h [3];
    logic [7:0]  dir_h [3];

    always #4 clk = ~clk;

    pwm_gate_select u_pwm_gate_select (
        .clk(clk), .rst_n(rst_n), .spi_on_i(spi_on), .pwm_en_i(pwm_en),
        .pwm_or_i(pwm_or), .pwm_shared_i(shared_pin), .pwm_direct_i(direct_pin),
        .fault_off_i(fault_off), .global_off_i(global_off), .gate_o(gate)
    );

    // Spread 8 direct pins over the outputs listed in R2.
    function automatic logic [15:0] spread(input logic [7:0] d);
        logic [15:0] r;
        int k;
        r = '0; k = 0;
        for (int b = 0; b < 16; b++) begin
            if (DIR_OUTS[b]) begin r[b] = d[k]; k++; end
        end
        return r;
    endfunction

    // Gate per requirements with the R8 ages: fault [0], control [1], pins [2].
    function automatic logic [15:0] model();
        logic [15:0] r, dv;
        dv = spread(dir_h[2]);
        for (int b = 0; b < 16; b++) begin
            if (en_h[1][b]) r[b] = or_h[1][b] ? (spi_h[1][b] | shr_h[2]) : (spi_h[1][b] & shr_h[2]);
            else            r[b] = spi_h[1][b] | dv[b];
        end
        return r & ~flt_h[0] & ~{16{glb_h[0]}};
    endfunction

    // Which requirement the first mismatching bit belongs to.
    function automatic string tag_of(input logic [15:0] diff);
        for (int b = 0; b < 16; b++) begin
            if (diff[b]) begin
                if (glb_h[0])      return "R7";
                if (flt_h[0][b])   return "R6";
                if (en_h[1][b])    return or_h[1][b] ? "R4" : "R3";
                if (DIR_OUTS[b])   return "R2";
                return "R1";
            end
        end
        return "R1";
    endfunction

    task automatic clear_hist();
        for (int k = 0; k < 3; k++) begin
            spi_h[k] = '0; en_h[k] = '0; or_h[k] = '0; flt_h[k] = '0;
            shr_h[k] = 1'b0; glb_h[k] = 1'b0; dir_h[k] = '0;
        end
    endtask

    task automatic drive(input logic [15:0] s, input logic [15:0] e, input logic [15:0] o,
                         input logic sh, input logic [7:0] d, input logic [15:0] f, input logic g);
        for (int k = 2; k > 0; k--) begin
            spi_h[k] = spi_h[k-1]; en_h[k] = en_h[k-1]; or_h[k] = or_h[k-1];
            flt_h[k] = flt_h[k-1]; shr_h[k] = shr_h[k-1]; glb_h[k] = glb_h[k-1];
            dir_h[k] = dir_h[k-1];
        end
        spi_h[0] = s; en_h[0] = e; or_h[0] = o; shr_h[0] = sh; dir_h[0] = d; flt_h[0] = f; glb_h[0] = g;
        spi_on = s; pwm_en = e; pwm_or = o; shared_pin = sh; direct_pin = d; fault_off = f; global_off = g;
    endtask

    task automatic check_exp(input string tag, input logic [15:0] exp);
        checks++;
        if (gate !== exp) begin
            errors++;
            $display("FAIL %s: gate=%h expected=%h", tag, gate, exp);
        end
    endtask

    task automatic check_model();
        logic [15:0] exp;
        exp = model();
        checks++;
        if (gate !== exp) begin
            errors++;
            $display("FAIL %s: gate=%h expected=%h", tag_of(gate ^ exp), gate, exp);
        end
    endtask

    // Drive a setting, let all latencies pass, then check against a constant.
    task automatic settle(input string tag, input logic [15:0] exp,
                          input logic [15:0] s, input logic [15:0] e, input logic [15:0] o,
                          input logic sh, input logic [7:0] d, input logic [15:0] f, input logic g);
        @(negedge clk); drive(s, e, o, sh, d, f, g);
        repeat (4) @(negedge clk);
        check_exp(tag, exp);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        clear_hist();
        // R9: inputs all high during reset, gates stay low.
        spi_on = '1; pwm_en = '1; pwm_or = '1; shared_pin = 1'b1; direct_pin = '1;
        repeat (4) begin
            @(negedge clk);
            check_exp("R9", 16'h0000);
        end
        @(negedge clk);
        spi_on = '0; pwm_en = '0; pwm_or = '0; shared_pin = 1'b0; direct_pin = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); check_exp("R9", 16'h0000);

        // R1: outputs without direct pins follow their on/off bits.
        settle("R1", 16'h3C3C, 16'h3C3C, '0, '0, 1'b0, 8'h00, '0, 1'b0);
        settle("R1", 16'h1408, 16'h1408, '0, '0, 1'b1, 8'h00, '0, 1'b0);
        // R2: direct pins OR in on their own outputs.
        settle("R2", 16'h8241, 16'h0000, '0, '0, 1'b0, 8'hA5, '0, 1'b0);
        settle("R2", 16'hC3C3, 16'h0000, '0, '0, 1'b0, 8'hFF, '0, 1'b0);
        // R3: AND mode.
        settle("R3", 16'h00FF, 16'h00FF, '1, '0, 1'b1, 8'h00, '0, 1'b0);
        settle("R3", 16'h0000, 16'h00FF, '1, '0, 1'b0, 8'h00, '0, 1'b0);
        // R4: OR mode.
        settle("R4", 16'h00FF, 16'h00FF, '1, '1, 1'b0, 8'h00, '0, 1'b0);
        settle("R4", 16'hFFFF, 16'h00FF, '1, '1, 1'b1, 8'h00, '0, 1'b0);
        // R5: direct pins ignored once PWM is enabled.
        settle("R5", 16'h0000, 16'h0000, '1, '0, 1'b0, 8'hFF, '0, 1'b0);
        // R6: per-output fault-off.
        settle("R6", 16'hFEFE, 16'hFFFF, '0, '0, 1'b0, 8'h00, 16'h0101, 1'b0);
        // R7: global shutdown.
        settle("R7", 16'h0000, 16'hFFFF, '0, '0, 1'b1, 8'hFF, '0, 1'b1);

        // R8: shared pin latency of three edges on output 3 (OR mode, on/off 0).
        settle("R8", 16'h0000, 16'h0000, 16'h0008, 16'h0008, 1'b0, 8'h00, '0, 1'b0);
        @(negedge clk); drive(16'h0000, 16'h0008, 16'h0008, 1'b1, 8'h00, '0, 1'b0);
        @(negedge clk); check_exp("R8", 16'h0000);
        @(negedge clk); check_exp("R8", 16'h0000);
        @(negedge clk); check_exp("R8", 16'h0008);
        // R8: control latency of two edges on output 2.
        drive(16'h0004, 16'h0008, 16'h0008, 1'b1, 8'h00, '0, 1'b0);
        @(negedge clk); check_exp("R8", 16'h0008);
        @(negedge clk); check_exp("R8", 16'h000C);
        // R8: fault latency of one edge.
        drive(16'h0004, 16'h0008, 16'h0008, 1'b1, 8'h00, 16'h0004, 1'b0);
        @(negedge clk); check_exp("R8", 16'h0008);

        // Random phase: every group changes each cycle; checked against the model.
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] f;
            logic g;
            f = 16'($urandom) & 16'($urandom) & 16'($urandom);
            g = ($urandom % 16) == 0;
            drive(16'($urandom), 16'($urandom), 16'($urandom), 1'($urandom),
                  8'($urandom), f, g);
            @(negedge clk);
            check_model();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule